// File: doc/BRIEF.md
# Retired Load Cache Event Classifier

This block turns a stream of retired load micro-op records into one-cycle pulses on eight cache event lines. The lines are all-loads, L1, L2 and L3 hit, L1, L2 and L3 miss, and fill-buffer hit. Each record states where the load found its data. The block decides which events that outcome raises. Hit events are exclusive. Miss events are inclusive. A fill-buffer hit stands apart from both. The pulses are meant for event counters, which are outside this block.

A mode input chooses between two kinds of accounting. In per-micro-op accounting, every accepted record produces its own pulses. In per-instruction accounting, the events of all micro-ops that share an instruction tag are OR-merged in a sticky register. The merged set is released as a single pulse group when the record flagged as the last of its instruction retires. As a result, each event fires at most once per instruction.

Top module: `load_event_classifier`

## Requirements
- R1: Level codes are 0 = L1, 1 = L2, 2 = L3, 3 = memory, 4 = filled from an already allocated fill buffer, and 5 to 7 = memory. In per-micro-op mode, an accepted cacheable record pulses, one clock after it is accepted: all-loads, plus exactly one hit event for the first level holding the line, or the miss events for a memory access.
- R2: A record with level code 4 pulses only all-loads and fill-buffer hit. It raises no L1/L2/L3 hit or miss.
- R3: Miss events are inclusive. An L3 miss always comes with L2 and L1 misses, and an L2 miss always comes with an L1 miss.
- R4: In per-micro-op mode, every L1 miss pulse comes with exactly one of L2 hit or L2 miss. Every L2 miss comes with exactly one of L3 hit or L3 miss.
- R5: In per-micro-op mode, in every cycle, all-loads equals the sum of fill-buffer hit, L1 hit, L2 hit, L3 hit and L3 miss.
- R6: In per-instruction mode (mode = 1), a record without the last flag produces no pulse. A last record produces, one clock later, all-loads once plus the OR of the events of every accepted micro-op of that instruction.
- R7: A cycle where valid is low or squash is high produces no pulses and adds nothing to a pending instruction.
- R8: A record with the cacheable flag low is treated as a memory access, whatever its level code says. It raises all-loads and the three miss events, with no hit and no fill-buffer hit.
- R9: In per-instruction mode, a record whose tag differs from that of a pending unfinished instruction discards the pending flags and sets the sequence error output. The error output stays set until reset. The record itself is then handled as a new instruction.
- R10: After reset, all event outputs and the error output are low and no instruction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_insn_mode | input | 1 | 1 = per-instruction accounting, 0 = per-micro-op |
| in_valid | input | 1 | A retired record is present |
| in_squash | input | 1 | The record was flushed; ignore it |
| in_tag | input | TAG_W | Instruction tag |
| in_last | input | 1 | Last micro-op of the instruction |
| in_cacheable | input | 1 | Access is to a cacheable memory type |
| in_level | input | LVL_W | Where the data was found (see R1) |
| ev_all | output | 1 | All-loads pulse |
| ev_l1_hit | output | 1 | L1 hit pulse |
| ev_l2_hit | output | 1 | L2 hit pulse |
| ev_l3_hit | output | 1 | L3 hit pulse |
| ev_l1_miss | output | 1 | L1 miss pulse |
| ev_l2_miss | output | 1 | L2 miss pulse |
| ev_l3_miss | output | 1 | L3 miss pulse |
| ev_fb_hit | output | 1 | Fill-buffer hit pulse |
| seq_err | output | 1 | Sticky sequence error |

## Verification
The assertions rely on the mode input being stable between the capture of a record and the cycle its pulses appear. They judge the per-micro-op relations against the mode sampled one clock earlier. They also assume that a mode change never happens while an instruction is pending. The stimulus changes the mode only in idle gaps when nothing is pending. It drives one record per two clocks, so every result can be sampled alone. Each sweep ends with a last record, with one exception: the directed error case, which leaves an instruction unfinished on purpose.

// File: rtl/load_event_classifier.sv
module load_event_classifier #(
  parameter int TAG_W = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_insn_mode,
  input  logic             in_valid,
  input  logic             in_squash,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_last,
  input  logic             in_cacheable,
  input  logic [LVL_W-1:0] in_level,
  output logic             ev_all,
  output logic             ev_l1_hit,
  output logic             ev_l2_hit,
  output logic             ev_l3_hit,
  output logic             ev_l1_miss,
  output logic             ev_l2_miss,
  output logic             ev_l3_miss,
  output logic             ev_fb_hit,
  output logic             seq_err
);
  localparam int NEV = 8;
  localparam logic [LVL_W-1:0] LV_L1  = LVL_W'(0);
  localparam logic [LVL_W-1:0] LV_L2  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LV_L3  = LVL_W'(2);
  localparam logic [LVL_W-1:0] LV_MEM = LVL_W'(3);
  localparam logic [LVL_W-1:0] LV_FB  = LVL_W'(4);

  logic             take;
  logic [LVL_W-1:0] lvl;
  logic             is_l1, is_l2, is_l3, is_fb, is_mem;
  logic [NEV-1:0]   cur, merged;
  logic [NEV-1:0]   pend_flags, out_q;
  logic [TAG_W-1:0] pend_tag;
  logic             pend_vld, err_q, mismatch;

  assign take   = in_valid & ~in_squash;
  assign lvl    = in_cacheable ? in_level : LV_MEM;
  assign is_l1  = (lvl == LV_L1);
  assign is_l2  = (lvl == LV_L2);
  assign is_l3  = (lvl == LV_L3);
  assign is_fb  = (lvl == LV_FB);
  assign is_mem = ~(is_l1 | is_l2 | is_l3 | is_fb);

  // {all, l1h, l2h, l3h, l1m, l2m, l3m, fb}
  assign cur = {1'b1, is_l1, is_l2, is_l3,
                ~is_l1 & ~is_fb, is_l3 | is_mem, is_mem, is_fb};

  assign mismatch = per_insn_mode & take & pend_vld & (in_tag != pend_tag);
  assign merged   = (mismatch | ~pend_vld) ? cur : (pend_flags | cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q      <= '0;
      pend_flags <= '0;
      pend_tag   <= '0;
      pend_vld   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      out_q <= '0;
      if (take) begin
        if (!per_insn_mode || in_last) begin
          out_q      <= per_insn_mode ? merged : cur;
          pend_flags <= '0;
          pend_vld   <= 1'b0;
        end else begin
          pend_flags <= merged;
          pend_vld   <= 1'b1;
          pend_tag   <= in_tag;
        end
        if (mismatch) err_q <= 1'b1;
      end
    end
  end

  assign {ev_all, ev_l1_hit, ev_l2_hit, ev_l3_hit,
          ev_l1_miss, ev_l2_miss, ev_l3_miss, ev_fb_hit} = out_q;
  assign seq_err = err_q;
endmodule

module load_event_classifier_chk #(
  parameter int TAG_W = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             per_insn_mode,
  input logic             in_valid,
  input logic             in_squash,
  input logic [TAG_W-1:0] in_tag,
  input logic             in_last,
  input logic             in_cacheable,
  input logic [LVL_W-1:0] in_level,
  input logic             ev_all,
  input logic             ev_l1_hit,
  input logic             ev_l2_hit,
  input logic             ev_l3_hit,
  input logic             ev_l1_miss,
  input logic             ev_l2_miss,
  input logic             ev_l3_miss,
  input logic             ev_fb_hit,
  input logic             seq_err
);
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_insn_mode) |-> $countones({ev_l1_hit, ev_l2_hit, ev_l3_hit, ev_fb_hit}) <= 1);
  a_r2_fb_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(per_insn_mode) && ev_fb_hit) |->
      !(ev_l1_hit || ev_l2_hit || ev_l3_hit || ev_l1_miss || ev_l2_miss || ev_l3_miss));
  a_r3_l3_incl: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l3_miss |-> (ev_l2_miss && ev_l1_miss));
  a_r3_l2_incl: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l2_miss |-> ev_l1_miss);
  a_r4_l1_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_insn_mode) |-> (ev_l1_miss == (ev_l2_hit ^ ev_l2_miss)) && !(ev_l2_hit && ev_l2_miss));
  a_r4_l2_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_insn_mode) |-> (ev_l2_miss == (ev_l3_hit ^ ev_l3_miss)) && !(ev_l3_hit && ev_l3_miss));
  a_r5_sum: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_insn_mode) |->
      $countones({ev_fb_hit, ev_l1_hit, ev_l2_hit, ev_l3_hit, ev_l3_miss}) == 32'(ev_all));
  a_r6_all_with_any: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_l1_hit || ev_l2_hit || ev_l3_hit || ev_l1_miss || ev_fb_hit) |-> ev_all);
  a_r7_no_record_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && !in_squash) |-> !ev_all);
  a_r8_uncached: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(per_insn_mode) && $past(in_valid && !in_squash && !in_cacheable)) |->
      (ev_l3_miss && !ev_fb_hit && !ev_l1_hit && !ev_l2_hit && !ev_l3_hit));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_err) |-> seq_err);
endmodule

bind load_event_classifier load_event_classifier_chk #(.TAG_W(TAG_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_load_event_classifier.sv
`timescale 1ns/1ps
module sim_load_event_classifier;
  logic clk = 1'b0, rst_n = 1'b0;
  logic per_insn_mode = 1'b0, in_valid = 1'b0, in_squash = 1'b0;
  logic [3:0] in_tag = '0;
  logic in_last = 1'b0, in_cacheable = 1'b0;
  logic [2:0] in_level = '0;
  logic ev_all, ev_l1_hit, ev_l2_hit, ev_l3_hit, ev_l1_miss, ev_l2_miss, ev_l3_miss, ev_fb_hit, seq_err;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  load_event_classifier u0 (.*);

  function automatic logic [7:0] obs();
    return {ev_all, ev_l1_hit, ev_l2_hit, ev_l3_hit, ev_l1_miss, ev_l2_miss, ev_l3_miss, ev_fb_hit};
  endfunction

  // expected {all,l1h,l2h,l3h,l1m,l2m,l3m,fb} from R1, R2, R3, R8
  function automatic logic [7:0] expv(input logic c, input int l);
    int e;
    logic mem;
    e = c ? l : 3;
    mem = (e == 3) || (e > 4);
    return {1'b1, e == 0, e == 1, e == 2, (e == 1) || (e == 2) || mem, (e == 2) || mem, mem, e == 4};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic send(input logic v, input logic sq, input logic [3:0] tag,
                      input logic last, input logic c, input logic [2:0] lvl);
    @(negedge clk);
    in_valid = v; in_squash = sq; in_tag = tag; in_last = last;
    in_cacheable = c; in_level = lvl;
    @(posedge clk);
    #1 in_valid = 1'b0; in_squash = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", obs(), 8'h00);
    chk_bit("R10 reset error", seq_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", obs(), 8'h00);

    // per-micro-op sweep
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < 8; l++)
        for (int sq = 0; sq < 2; sq++) begin
          logic [7:0] o, e;
          string req;
          send(1'b1, sq[0], 4'(l), 1'b1, c[0], 3'(l));
          o = obs();
          e = sq ? 8'h00 : expv(c[0], l);
          req = sq ? "R7 squashed" : (c == 0) ? "R8 uncached" : (l == 4) ? "R2 fill buffer" : "R1 level";
          chk(req, o, e);
          chk_bit("R5 sum", o[7], 1'(o[0] + o[6] + o[5] + o[4] + o[1]));
          chk_bit("R4 pair L1", o[3], o[5] ^ o[2]);
          chk_bit("R3 incl", o[1] & ~o[2], 1'b0);
        end
    send(1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 3'd0);
    chk("R7 idle", obs(), 8'h00);

    // per-instruction sweep over two-uop instructions
    @(negedge clk);
    per_insn_mode = 1'b1;
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++) begin
        logic [3:0] t;
        t = 4'(a * 10 + b);
        send(1'b1, 1'b0, t, 1'b0, a[0], 3'(a / 2));
        chk("R6 non-last silent", obs(), 8'h00);
        send(1'b1, 1'b0, t, 1'b1, b[0], 3'(b / 2));
        chk("R6 merged", obs(), expv(a[0], a / 2) | expv(b[0], b / 2));
      end

    // squashed uop inside an instruction
    send(1'b1, 1'b0, 4'd3, 1'b0, 1'b1, 3'd0);
    send(1'b1, 1'b1, 4'd3, 1'b0, 1'b1, 3'd4);
    chk("R7 squashed mid", obs(), 8'h00);
    send(1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 3'd1);
    chk("R7 squash not merged", obs(), expv(1'b1, 0) | expv(1'b1, 1));
    chk_bit("R9 no error yet", seq_err, 1'b0);

    // three uops all L1 hit: one pulse
    send(1'b1, 1'b0, 4'd9, 1'b0, 1'b1, 3'd0);
    send(1'b1, 1'b0, 4'd9, 1'b0, 1'b1, 3'd0);
    send(1'b1, 1'b0, 4'd9, 1'b1, 1'b1, 3'd0);
    chk("R6 once per insn", obs(), 8'b1100_0000);

    // orphaned instruction
    send(1'b1, 1'b0, 4'd5, 1'b0, 1'b1, 3'd3);
    send(1'b1, 1'b0, 4'd6, 1'b1, 1'b1, 3'd0);
    chk("R9 pending dropped", obs(), expv(1'b1, 0));
    chk_bit("R9 error set", seq_err, 1'b1);
    send(1'b1, 1'b0, 4'd7, 1'b1, 1'b1, 3'd4);
    chk("R9 normal after", obs(), expv(1'b1, 4));
    chk_bit("R9 error sticky", seq_err, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule